// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the purely combinational hazard logic of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Every cycle it looks at the register numbers that the decode and execute instructions read, and at the destinations of the instructions further down the pipe. From these it decides three things. First, where each ALU operand in execute should come from. Second, whether decode must read the value being written back in this same cycle. Third, whether the front of the pipe must hold, be bubbled or be flushed.

A load in execute whose destination is needed by the instruction in decode cannot be served by forwarding. The unit then freezes PC and the fetch/decode register and turns the decode instruction's control into a bubble that writes nothing. Branches are resolved in decode and are predicted not taken. A taken branch flushes the one instruction fetched behind it, which costs one cycle. If a load-use stall and a taken indication arrive together, the stall wins. The branch is held in decode and re-evaluated in the next cycle, so nothing is flushed.

Forwarding select encoding: 2'b00 takes the register-file value, 2'b01 takes the write-back result, and 2'b10 takes the memory-stage (execute/memory) result. 2'b11 is never produced.

Top module: `hazard_fwd_unit`

## Requirements
- R1: `fwd_a_o` is 2'b10 when `mem_wen_i` is 1, `mem_rd_i` is nonzero and equals `ex_rs_i`.
- R2: `fwd_a_o` is 2'b01 when `wb_wen_i` is 1, `wb_rd_i` is nonzero and equals `ex_rs_i`, and the memory-stage condition of R1 does not hold.
- R3: When both the memory and write-back stages qualify for the same operand, the select is 2'b10.
- R4: Register 0 is never forwarded or bypassed, and a load to register 0 never stalls.
- R5: A stage whose write enable is 0 is never a forwarding source. With no qualifying source the select is 2'b00.
- R6: `fwd_b_o` follows the R1 to R5 rules using `ex_rt_i` in place of `ex_rs_i`, independently of operand A.
- R7: `id_byp_a_o` / `id_byp_b_o` is 1 when `wb_wen_i` is 1 and `wb_rd_i` is nonzero and equals `id_rs_i` / `id_rt_i` respectively.
- R8: `stall_o` is 1 when `ex_load_i` and `ex_wen_i` are 1 and `ex_rd_i` is nonzero and equals `id_rs_i` or `id_rt_i`.
- R9: `bubble_o` is asserted in exactly the cycles where `stall_o` is asserted.
- R10: `flush_o` is 1 when `id_br_taken_i` is 1 and no stall is raised.
- R11: When a stall and a taken indication fall in the same cycle, `stall_o` and `bubble_o` are 1 and `flush_o` is 0.
- R12: An execute instruction that writes a matching register but is not a load never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | AW | First source register of the decode instruction |
| id_rt_i | input | AW | Second source register of the decode instruction |
| ex_rs_i | input | AW | First source register of the execute instruction |
| ex_rt_i | input | AW | Second source register of the execute instruction |
| ex_rd_i | input | AW | Destination register of the execute instruction |
| ex_wen_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction reads data memory |
| mem_rd_i | input | AW | Destination register in the memory stage |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| wb_rd_i | input | AW | Destination register in write-back |
| wb_wen_i | input | 1 | Write-back instruction writes a register |
| id_br_taken_i | input | 1 | Branch in decode resolves taken |
| fwd_a_o | output | 2 | Source select for ALU operand A |
| fwd_b_o | output | 2 | Source select for ALU operand B |
| id_byp_a_o | output | 1 | Decode operand A takes the write-back value |
| id_byp_b_o | output | 1 | Decode operand B takes the write-back value |
| stall_o | output | 1 | Hold PC and the fetch/decode register |
| bubble_o | output | 1 | Zero the control of the decode instruction entering execute |
| flush_o | output | 1 | Clear the fetch/decode register |

## Verification
Two functions can coincide in one cycle: a load-use stall and a taken branch in decode. The bench provokes this by presenting a load in execute whose destination matches a decode source while the taken input is high. It expects stall and bubble high and flush low. A second overlap is a memory-stage result and a write-back result that both match one execute source. Here only the memory-stage select may appear, and the other operand must keep its own independent select.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_wen_i,
    input  logic [AW-1:0] wb_rd_i,
    input  logic          wb_wen_i,
    output hzd_pkg::fwd_sel_e sel_o
);
    import hzd_pkg::*;

    logic src_live;
    logic hit_mem;
    logic hit_wb;

    assign src_live = (src_i != '0);
    assign hit_mem  = src_live && mem_wen_i && (mem_rd_i == src_i);
    assign hit_wb   = src_live && wb_wen_i  && (wb_rd_i  == src_i);

    always_comb begin
        unique case ({hit_mem, hit_wb})
            2'b10, 2'b11: sel_o = FWD_MEM;
            2'b01:        sel_o = FWD_WB;
            default:      sel_o = FWD_RF;
        endcase
    end
endmodule

// File: rtl/hzd_loaduse.sv
module hzd_loaduse #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs_i,
    input  logic [AW-1:0] id_rt_i,
    input  logic [AW-1:0] ex_rd_i,
    input  logic          ex_wen_i,
    input  logic          ex_load_i,
    output logic          hit_o
);
    logic pending_load;

    assign pending_load = ex_load_i && ex_wen_i && (ex_rd_i != '0);
    assign hit_o = pending_load && ((ex_rd_i == id_rs_i) || (ex_rd_i == id_rt_i));
endmodule

// File: rtl/hzd_front_ctrl.sv
module hzd_front_ctrl (
    input  logic load_hit_i,
    input  logic br_taken_i,
    output logic stall_o,
    output logic bubble_o,
    output logic flush_o
);
    typedef enum logic [1:0] {
        FRONT_RUN   = 2'b00,
        FRONT_HOLD  = 2'b01,
        FRONT_CLEAR = 2'b10
    } front_act_e;

    front_act_e act;

    always_comb begin
        if (load_hit_i)      act = FRONT_HOLD;
        else if (br_taken_i) act = FRONT_CLEAR;
        else                 act = FRONT_RUN;
    end

    always_comb begin
        stall_o  = 1'b0;
        bubble_o = 1'b0;
        flush_o  = 1'b0;
        unique case (act)
            FRONT_HOLD: begin
                stall_o  = 1'b1;
                bubble_o = 1'b1;
            end
            FRONT_CLEAR: flush_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs_i,
    input  logic [AW-1:0] id_rt_i,
    input  logic [AW-1:0] ex_rs_i,
    input  logic [AW-1:0] ex_rt_i,
    input  logic [AW-1:0] ex_rd_i,
    input  logic          ex_wen_i,
    input  logic          ex_load_i,
    input  logic [AW-1:0] mem_rd_i,
    input  logic          mem_wen_i,
    input  logic [AW-1:0] wb_rd_i,
    input  logic          wb_wen_i,
    input  logic          id_br_taken_i,
    output logic [1:0]    fwd_a_o,
    output logic [1:0]    fwd_b_o,
    output logic          id_byp_a_o,
    output logic          id_byp_b_o,
    output logic          stall_o,
    output logic          bubble_o,
    output logic          flush_o
);
    import hzd_pkg::*;

    localparam int NOPS = 2;

    logic [NOPS-1:0][AW-1:0] ex_src;
    logic [NOPS-1:0][AW-1:0] id_src;
    fwd_sel_e                sel [NOPS];
    logic [NOPS-1:0]         byp;
    logic                    load_hit;

    assign ex_src[0] = ex_rs_i;
    assign ex_src[1] = ex_rt_i;
    assign id_src[0] = id_rs_i;
    assign id_src[1] = id_rt_i;

    for (genvar g = 0; g < NOPS; g++) begin : g_opnd
        hzd_fwd_pick #(.AW(AW)) u_pick (
            .src_i     (ex_src[g]),
            .mem_rd_i  (mem_rd_i),
            .mem_wen_i (mem_wen_i),
            .wb_rd_i   (wb_rd_i),
            .wb_wen_i  (wb_wen_i),
            .sel_o     (sel[g])
        );
        assign byp[g] = wb_wen_i && (wb_rd_i != '0) && (wb_rd_i == id_src[g]);
    end

    assign fwd_a_o    = sel[0];
    assign fwd_b_o    = sel[1];
    assign id_byp_a_o = byp[0];
    assign id_byp_b_o = byp[1];

    hzd_loaduse #(.AW(AW)) u_loaduse (
        .id_rs_i   (id_rs_i),
        .id_rt_i   (id_rt_i),
        .ex_rd_i   (ex_rd_i),
        .ex_wen_i  (ex_wen_i),
        .ex_load_i (ex_load_i),
        .hit_o     (load_hit)
    );

    hzd_front_ctrl u_front (
        .load_hit_i (load_hit),
        .br_taken_i (id_br_taken_i),
        .stall_o    (stall_o),
        .bubble_o   (bubble_o),
        .flush_o    (flush_o)
    );
endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] id_rs_i,
    input logic [AW-1:0] id_rt_i,
    input logic [AW-1:0] ex_rs_i,
    input logic [AW-1:0] ex_rt_i,
    input logic [AW-1:0] ex_rd_i,
    input logic          ex_wen_i,
    input logic          ex_load_i,
    input logic [AW-1:0] mem_rd_i,
    input logic          mem_wen_i,
    input logic [AW-1:0] wb_rd_i,
    input logic          wb_wen_i,
    input logic          id_br_taken_i,
    input logic [1:0]    fwd_a_o,
    input logic [1:0]    fwd_b_o,
    input logic          id_byp_a_o,
    input logic          id_byp_b_o,
    input logic          stall_o,
    input logic          bubble_o,
    input logic          flush_o
);
    always_comb begin
        // R3: memory stage wins when it qualifies
        if (mem_wen_i && mem_rd_i != '0 && mem_rd_i == ex_rs_i)
            assert_fwd_prio_R3: assert (fwd_a_o == 2'b10);
        // R4: register 0 never forwarded
        if (ex_rs_i == '0)
            assert_zero_nofwd_R4: assert (fwd_a_o == 2'b00);
        // R5: a selected source must have its write enable
        if (fwd_b_o == 2'b10)
            assert_wen_mem_R5: assert (mem_wen_i);
        if (fwd_b_o == 2'b01)
            assert_wen_wb_R5: assert (wb_wen_i);
        // R9: bubble tracks stall
        assert_bubble_R9: assert (bubble_o == stall_o);
        // R11: never flush while stalled
        assert_no_flush_stall_R11: assert (!(flush_o && stall_o));
        // R10: flush only from a taken branch
        if (flush_o)
            assert_flush_cause_R10: assert (id_br_taken_i);
        // R12: stall only behind a load
        if (stall_o)
            assert_stall_load_R12: assert (ex_load_i && ex_wen_i);
        // R7: bypass only from an enabled write-back
        if (id_byp_a_o || id_byp_b_o)
            assert_byp_wen_R7: assert (wb_wen_i && wb_rd_i != '0);
    end
endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/hazard_fwd_unit_bench.sv
module hazard_fwd_unit_bench;
    localparam int AW = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0] id_rs = '0, id_rt = '0, ex_rs = '0, ex_rt = '0, ex_rd = '0;
    logic [AW-1:0] mem_rd = '0, wb_rd = '0;
    logic ex_wen = 1'b0, ex_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0, taken = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic byp_a, byp_b, stall, bubble, flush;

    hazard_fwd_unit #(.AW(AW)) u_hazard_fwd_unit (
        .id_rs_i(id_rs), .id_rt_i(id_rt), .ex_rs_i(ex_rs), .ex_rt_i(ex_rt),
        .ex_rd_i(ex_rd), .ex_wen_i(ex_wen), .ex_load_i(ex_load),
        .mem_rd_i(mem_rd), .mem_wen_i(mem_wen), .wb_rd_i(wb_rd), .wb_wen_i(wb_wen),
        .id_br_taken_i(taken), .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
        .id_byp_a_o(byp_a), .id_byp_b_o(byp_b), .stall_o(stall),
        .bubble_o(bubble), .flush_o(flush)
    );

    typedef struct {
        logic [1:0] fa;
        logic [1:0] fb;
        logic       ba;
        logic       bb;
        logic       st;
        logic       fl;
        string      tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic drive(
        input int irs, input int irt, input int ers, input int ert,
        input int erd, input bit ew, input bit el,
        input int mrd, input bit mw, input int wrd, input bit ww, input bit tk,
        input logic [1:0] fa, input logic [1:0] fb, input bit ba, input bit bb,
        input bit st, input bit fl, input string tag);
        exp_t e;
        @(negedge clk);
        id_rs = irs[AW-1:0]; id_rt = irt[AW-1:0];
        ex_rs = ers[AW-1:0]; ex_rt = ert[AW-1:0]; ex_rd = erd[AW-1:0];
        ex_wen = ew; ex_load = el; mem_rd = mrd[AW-1:0]; mem_wen = mw;
        wb_rd = wrd[AW-1:0]; wb_wen = ww; taken = tk;
        e.fa = fa; e.fb = fb; e.ba = ba; e.bb = bb; e.st = st; e.fl = fl; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: inputs settle at negedge, compare at posedge
    always @(posedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (fwd_a !== e.fa || fwd_b !== e.fb || byp_a !== e.ba || byp_b !== e.bb ||
                stall !== e.st || bubble !== e.st || flush !== e.fl) begin
                errors++;
                $display("FAIL %s: got fa=%b fb=%b ba=%b bb=%b st=%b bu=%b fl=%b exp fa=%b fb=%b ba=%b bb=%b st=%b bu=%b fl=%b",
                         e.tag, fwd_a, fwd_b, byp_a, byp_b, stall, bubble, flush,
                         e.fa, e.fb, e.ba, e.bb, e.st, e.st, e.fl);
            end
        end
    end

    initial begin
        // reset/idle state: nothing selected (R5, R9)
        drive(0,0,0,0, 0,0,0, 0,0, 0,0, 0, 2'b00,2'b00,0,0,0,0, "R5");
        // R1: memory-stage forward on A
        drive(1,2,3,2, 0,0,0, 3,1, 0,0, 0, 2'b10,2'b00,0,0,0,0, "R1");
        // R2: write-back forward when memory stage targets another reg
        drive(1,2,4,2, 0,0,0, 7,1, 4,1, 0, 2'b01,2'b00,0,0,0,0, "R2");
        // R3: both match, memory stage wins
        drive(1,2,5,2, 0,0,0, 5,1, 5,1, 0, 2'b10,2'b00,0,0,0,0, "R3");
        // R4: register 0 never forwarded nor bypassed
        drive(0,0,0,0, 0,0,0, 0,1, 0,1, 0, 2'b00,2'b00,0,0,0,0, "R4");
        // R4: load to register 0 with decode reading 0 does not stall
        drive(0,3,1,1, 0,1,1, 0,0, 0,0, 0, 2'b00,2'b00,0,0,0,0, "R4");
        // R5: disabled writes ignored
        drive(1,2,6,6, 0,0,0, 6,0, 6,0, 0, 2'b00,2'b00,0,0,0,0, "R5");
        // R5: memory disabled, write-back enabled
        drive(1,2,6,2, 0,0,0, 6,0, 6,1, 0, 2'b01,2'b00,0,0,0,0, "R5");
        // R6: operand B independent of A
        drive(1,2,2,9, 0,0,0, 9,1, 0,0, 0, 2'b00,2'b10,0,0,0,0, "R6");
        drive(1,2,8,8, 0,0,0, 3,1, 8,1, 0, 2'b01,2'b01,0,0,0,0, "R6");
        drive(1,2,11,12, 0,0,0, 11,1, 12,1, 0, 2'b10,2'b01,0,0,0,0, "R6");
        // R7: decode same-cycle bypass
        drive(12,13,1,1, 0,0,0, 0,0, 13,1, 0, 2'b00,2'b00,0,1,0,0, "R7");
        drive(14,14,1,1, 0,0,0, 0,0, 14,1, 0, 2'b00,2'b00,1,1,0,0, "R7");
        drive(14,15,1,1, 0,0,0, 0,0, 14,0, 0, 2'b00,2'b00,0,0,0,0, "R7");
        // R8: load-use on rs, then on rt (R9 bubble with it)
        drive(10,4,1,1, 10,1,1, 0,0, 0,0, 0, 2'b00,2'b00,0,0,1,0, "R8");
        drive(4,10,1,1, 10,1,1, 0,0, 0,0, 0, 2'b00,2'b00,0,0,1,0, "R9");
        // R8: load with no match
        drive(4,5,1,1, 10,1,1, 0,0, 0,0, 0, 2'b00,2'b00,0,0,0,0, "R8");
        // R12: ALU op writing a matching reg does not stall
        drive(10,4,1,1, 10,1,0, 0,0, 0,0, 0, 2'b00,2'b00,0,0,0,0, "R12");
        // R10: taken branch flushes
        drive(4,5,1,1, 0,0,0, 0,0, 0,0, 1, 2'b00,2'b00,0,0,0,1, "R10");
        // R10: taken with non-matching load still flushes
        drive(4,5,1,1, 9,1,1, 0,0, 0,0, 1, 2'b00,2'b00,0,0,0,1, "R10");
        // R11: stall and taken together
        drive(10,5,1,1, 10,1,1, 0,0, 0,0, 1, 2'b00,2'b00,0,0,1,0, "R11");
        // back to idle
        drive(0,0,0,0, 0,0,0, 0,0, 0,0, 0, 2'b00,2'b00,0,0,0,0, "R9");
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got done=0 expected done=1");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule